// File: doc/BRIEF.md
# Dual-Clock FIFO with Reset-Selected Modes

This block is a first-in first-out buffer, 9 bits wide and 256 words deep. Its write side and its read side run on independent clocks, and the two clocks may also be the same clock. The write and read pointers cross between the two domains as Gray code through two-flop synchronizers. Because every flag is computed from a synchronized copy of the far pointer, a flag can report a change a few cycles late but never early. Four active-low status flags are provided: full, almost-full, empty and almost-empty. Reads are registered into an output register. An output enable either presents that register or marks the output as not driven.

One write-side control input has two uses, and its level while reset is held picks which one applies. If it is high during reset, it acts as a second, active-high write enable, which lets several buffers be chained in depth. If it is low during reset, it acts as an active-low load strobe. Each strobed write then places its low data byte into one of four offset bytes, and these bytes set the almost-empty and almost-full thresholds.

Reset is synchronous and active low. It must be held for several edges of both clocks.

Top module: `dcfifo_modes`

## Requirements
- R1: While rst_n is low, each rising edge of a clock sets the flags of that clock's domain: full_n and afull_n go high on the write clock, and empty_n and aempty_n go low on the read clock. The read clock also clears the output register to zero, so dout reads 0 with oe_n low right after reset.
- R2: The mode is the level of wr_en2_ld sampled on the write clock while rst_n is low. A value of 1 selects dual-enable mode and 0 selects programmable-threshold mode. The mode then holds until the next reset.
- R3: In dual-enable mode, a word is stored on a rising write-clock edge only when wr_en1_n is 0 and wr_en2_ld is 1. Any other combination stores nothing, and in this mode the offset bytes are never loaded.
- R4: In programmable-threshold mode, wr_en1_n = 0 with wr_en2_ld = 1 stores a word. wr_en1_n = 0 with wr_en2_ld = 0 instead loads din[7:0] into an offset byte and not into the array. Successive loads go in the fixed order: empty-threshold low byte, empty-threshold high byte, full-threshold low byte, full-threshold high byte, then back to the first.
- R5: A word moves from the array to the output register on a rising read-clock edge only when rd_en1_n and rd_en2_n are both 0. If either of them is 1, the output register keeps its value.
- R6: empty_n is 0 exactly when the read side sees no stored word. Reads requested while empty_n is 0 are ignored. empty_n returns to 1 within a few read-clock edges after a write.
- R7: full_n falls on the write-clock edge that stores the 256th word. Writes attempted while full_n is 0 are ignored. full_n returns to 1 within a few write-clock edges after a read.
- R8: aempty_n is 0 when the stored word count is at or below the 16-bit empty threshold, which is 7 after reset.
- R9: afull_n is 0 when the free space is at or below the 16-bit full threshold, which is 7 after reset. It changes on the write edge that crosses that level.
- R10: With oe_n = 1, dout is all zeros and dout_drive is 0. With oe_n = 0, dout_drive is 1 and dout carries the output register.
- R11: Words leave in the order they were stored, with all 9 bits intact.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| wr_clk | input | 1 | Write-side clock |
| rd_clk | input | 1 | Read-side clock |
| rst_n | input | 1 | Synchronous active-low reset for both domains |
| wr_en1_n | input | 1 | Primary write enable, active low |
| wr_en2_ld | input | 1 | Second write enable (dual mode) or offset-load strobe, active low (threshold mode); sampled in reset to pick the mode |
| din | input | 9 | Write data; bits 7:0 also feed offset loads |
| rd_en1_n | input | 1 | Read enable one, active low |
| rd_en2_n | input | 1 | Read enable two, active low |
| oe_n | input | 1 | Output enable, active low |
| dout | output | 9 | Output register contents, or zero when not enabled |
| dout_drive | output | 1 | High when dout is valid (stand-in for a driven pad) |
| full_n | output | 1 | Full flag, active low, write clock |
| afull_n | output | 1 | Almost-full flag, active low, write clock |
| empty_n | output | 1 | Empty flag, active low, read clock |
| aempty_n | output | 1 | Almost-empty flag, active low, read clock |

## Verification
The main data path is exercised with a mix of bit patterns. Alternating bits, all ones, all zeros, the top bit alone and the low byte alone show that none of the 9 bits is swapped or stuck. Read attempts with only one read enable low show that the output register holds unless both enables are low. Store-and-drain runs of 256 words are made in each mode. In dual-enable mode, the run separates the exact full boundary from an ignored extra write. In threshold mode, it separates array writes from offset loads and shows that the load order wraps. Flag levels are checked one word either side of each threshold, with both the default and the loaded offsets.

// File: rtl/dcfifo_pkg.sv
`timescale 1ns/1ps
package dcfifo_pkg;
  // Operating mode, latched while reset is held
  typedef enum logic {
    MODE_THRESH = 1'b0,
    MODE_DUALWE = 1'b1
  } fifo_mode_e;

  // Offset byte selector; the order is behaviour (load sequence)
  typedef enum logic [1:0] {
    OFS_EMPTY_LO = 2'd0,
    OFS_EMPTY_HI = 2'd1,
    OFS_FULL_LO  = 2'd2,
    OFS_FULL_HI  = 2'd3
  } ofs_sel_e;

  localparam int DEFAULT_THRESHOLD = 7;
endpackage

// File: rtl/dcfifo_xing.sv
`timescale 1ns/1ps
module dcfifo_xing #(
  parameter int PW     = 9,
  parameter int STAGES = 2
) (
  input  logic          dst_clk,
  input  logic          rst_n,
  input  logic [PW-1:0] src_gray,
  output logic [PW-1:0] dst_bin
);
  logic [PW-1:0] stg [STAGES];

  function automatic logic [PW-1:0] gray_to_bin(input logic [PW-1:0] g);
    logic [PW-1:0] b;
    b[PW-1] = g[PW-1];
    for (int i = PW - 2; i >= 0; i--) b[i] = b[i+1] ^ g[i];
    return b;
  endfunction

  generate
    for (genvar s = 0; s < STAGES; s++) begin : g_stage
      always_ff @(posedge dst_clk) begin
        if (!rst_n) stg[s] <= '0;
        else if (s == 0) stg[s] <= src_gray;
        else stg[s] <= stg[(s == 0) ? 0 : s-1];
      end
    end
  endgenerate

  assign dst_bin = gray_to_bin(stg[STAGES-1]);
endmodule

// File: rtl/dcfifo_ram.sv
`timescale 1ns/1ps
module dcfifo_ram #(
  parameter int DW = 9,
  parameter int AW = 8
) (
  input  logic          wr_clk,
  input  logic          we,
  input  logic [AW-1:0] waddr,
  input  logic [DW-1:0] wdata,
  input  logic [AW-1:0] raddr,
  output logic [DW-1:0] rdata
);
  localparam int DEPTH = 1 << AW;
  logic [DW-1:0] cells [DEPTH];

  always_ff @(posedge wr_clk) begin
    if (we) cells[waddr] <= wdata;
  end

  assign rdata = cells[raddr];
endmodule

// File: rtl/dcfifo_wside.sv
`timescale 1ns/1ps
module dcfifo_wside
  import dcfifo_pkg::*;
#(
  parameter int DW   = 9,
  parameter int AW   = 8,
  parameter int OW   = 8,
  parameter int DEFT = DEFAULT_THRESHOLD
) (
  input  logic            wr_clk,
  input  logic            rst_n,
  input  logic            wr_en1_n,
  input  logic            wr_en2_ld,
  input  logic [DW-1:0]   din,
  input  logic [AW:0]     rptr_sync,
  output logic [AW:0]     wptr_gray,
  output logic            mem_we,
  output logic [AW-1:0]   mem_waddr,
  output logic [DW-1:0]   mem_wdata,
  output logic [2*OW-1:0] empty_thr,
  output logic [2*OW-1:0] full_thr,
  output logic            mode_dual,
  output logic            wr_fire,
  output logic            ofs_load,
  output logic            full_n,
  output logic            afull_n
);
  localparam int PW    = AW + 1;
  localparam int DEPTH = 1 << AW;
  localparam int OFFW  = 2 * OW;
  localparam logic [OFFW-1:0] DEF_V = OFFW'(DEFT);

  fifo_mode_e    mode_q;
  ofs_sel_e      sel_q;
  logic [OW-1:0] ofs_q [4];
  logic [PW-1:0] wptr_q, wgray_q, wptr_next, used_next;
  logic          full_n_q, afull_n_q;

  function automatic logic [PW-1:0] to_gray(input logic [PW-1:0] b);
    return b ^ (b >> 1);
  endfunction

  function automatic logic [PW-1:0] free_of(input logic [PW-1:0] used);
    return PW'(DEPTH) - used;
  endfunction

  function automatic logic at_or_below(input logic [PW-1:0] lvl,
                                       input logic [OFFW-1:0] thr);
    return OFFW'(lvl) <= thr;
  endfunction

  // Data write request has the same pin levels in both modes
  assign wr_fire   = !wr_en1_n && wr_en2_ld && full_n_q;
  assign ofs_load  = (mode_q == MODE_THRESH) && !wr_en1_n && !wr_en2_ld;
  assign wptr_next = wptr_q + PW'(wr_fire);
  assign used_next = wptr_next - rptr_sync;

  always_ff @(posedge wr_clk) begin
    if (!rst_n) begin
      mode_q    <= wr_en2_ld ? MODE_DUALWE : MODE_THRESH;
      sel_q     <= OFS_EMPTY_LO;
      ofs_q[0]  <= DEF_V[OW-1:0];
      ofs_q[1]  <= DEF_V[OFFW-1:OW];
      ofs_q[2]  <= DEF_V[OW-1:0];
      ofs_q[3]  <= DEF_V[OFFW-1:OW];
      wptr_q    <= '0;
      wgray_q   <= '0;
      full_n_q  <= 1'b1;
      afull_n_q <= 1'b1;
    end else begin
      if (ofs_load) begin
        ofs_q[sel_q] <= din[OW-1:0];
        sel_q        <= ofs_sel_e'(sel_q + 2'd1);
      end
      wptr_q    <= wptr_next;
      wgray_q   <= to_gray(wptr_next);
      full_n_q  <= (used_next != PW'(DEPTH));
      afull_n_q <= !at_or_below(free_of(used_next), full_thr);
    end
  end

  assign wptr_gray = wgray_q;
  assign mem_we    = wr_fire;
  assign mem_waddr = wptr_q[AW-1:0];
  assign mem_wdata = din;
  assign empty_thr = {ofs_q[OFS_EMPTY_HI], ofs_q[OFS_EMPTY_LO]};
  assign full_thr  = {ofs_q[OFS_FULL_HI], ofs_q[OFS_FULL_LO]};
  assign mode_dual = (mode_q == MODE_DUALWE);
  assign full_n    = full_n_q;
  assign afull_n   = afull_n_q;
endmodule

// File: rtl/dcfifo_rside.sv
`timescale 1ns/1ps
module dcfifo_rside #(
  parameter int DW = 9,
  parameter int AW = 8,
  parameter int OW = 8
) (
  input  logic            rd_clk,
  input  logic            rst_n,
  input  logic            rd_en1_n,
  input  logic            rd_en2_n,
  input  logic [AW:0]     wptr_sync,
  input  logic [2*OW-1:0] empty_thr,
  input  logic [DW-1:0]   mem_rdata,
  output logic [AW-1:0]   mem_raddr,
  output logic [AW:0]     rptr_gray,
  output logic            rd_fire,
  output logic [DW-1:0]   dout_q,
  output logic            empty_n,
  output logic            aempty_n
);
  localparam int PW   = AW + 1;
  localparam int OFFW = 2 * OW;

  logic [PW-1:0] rptr_q, rgray_q, rptr_next, level_next;
  logic [DW-1:0] oreg_q;
  logic          empty_n_q, aempty_n_q;

  function automatic logic [PW-1:0] to_gray(input logic [PW-1:0] b);
    return b ^ (b >> 1);
  endfunction

  function automatic logic at_or_below(input logic [PW-1:0] lvl,
                                       input logic [OFFW-1:0] thr);
    return OFFW'(lvl) <= thr;
  endfunction

  assign rd_fire    = !rd_en1_n && !rd_en2_n && empty_n_q;
  assign rptr_next  = rptr_q + PW'(rd_fire);
  assign level_next = wptr_sync - rptr_next;

  always_ff @(posedge rd_clk) begin
    if (!rst_n) begin
      rptr_q     <= '0;
      rgray_q    <= '0;
      oreg_q     <= '0;
      empty_n_q  <= 1'b0;
      aempty_n_q <= 1'b0;
    end else begin
      rptr_q     <= rptr_next;
      rgray_q    <= to_gray(rptr_next);
      empty_n_q  <= (level_next != '0);
      aempty_n_q <= !at_or_below(level_next, empty_thr);
      if (rd_fire) oreg_q <= mem_rdata;
    end
  end

  assign mem_raddr = rptr_q[AW-1:0];
  assign rptr_gray = rgray_q;
  assign dout_q    = oreg_q;
  assign empty_n   = empty_n_q;
  assign aempty_n  = aempty_n_q;
endmodule

// File: rtl/dcfifo_modes.sv
`timescale 1ns/1ps
module dcfifo_modes #(
  parameter int DW          = 9,
  parameter int AW          = 8,
  parameter int OW          = 8,
  parameter int SYNC_STAGES = 2
) (
  input  logic          wr_clk,
  input  logic          rd_clk,
  input  logic          rst_n,
  input  logic          wr_en1_n,
  input  logic          wr_en2_ld,
  input  logic [DW-1:0] din,
  input  logic          rd_en1_n,
  input  logic          rd_en2_n,
  input  logic          oe_n,
  output logic [DW-1:0] dout,
  output logic          dout_drive,
  output logic          full_n,
  output logic          afull_n,
  output logic          empty_n,
  output logic          aempty_n
);
  localparam int PW   = AW + 1;
  localparam int OFFW = 2 * OW;

  // Named internal events, used by the bound checker
  logic            wr_fire, rd_fire, ofs_load, mode_dual;
  logic [DW-1:0]   dout_q;
  logic [PW-1:0]   wptr_gray, rptr_gray, wptr_sync, rptr_sync;
  logic            mem_we;
  logic [AW-1:0]   mem_waddr, mem_raddr;
  logic [DW-1:0]   mem_wdata, mem_rdata;
  logic [OFFW-1:0] empty_thr, full_thr;

  dcfifo_wside #(.DW(DW), .AW(AW), .OW(OW)) u_wside (
    .wr_clk(wr_clk), .rst_n(rst_n), .wr_en1_n(wr_en1_n), .wr_en2_ld(wr_en2_ld),
    .din(din), .rptr_sync(rptr_sync), .wptr_gray(wptr_gray),
    .mem_we(mem_we), .mem_waddr(mem_waddr), .mem_wdata(mem_wdata),
    .empty_thr(empty_thr), .full_thr(full_thr), .mode_dual(mode_dual),
    .wr_fire(wr_fire), .ofs_load(ofs_load), .full_n(full_n), .afull_n(afull_n)
  );

  dcfifo_xing #(.PW(PW), .STAGES(SYNC_STAGES)) u_w2r (
    .dst_clk(rd_clk), .rst_n(rst_n), .src_gray(wptr_gray), .dst_bin(wptr_sync)
  );

  dcfifo_xing #(.PW(PW), .STAGES(SYNC_STAGES)) u_r2w (
    .dst_clk(wr_clk), .rst_n(rst_n), .src_gray(rptr_gray), .dst_bin(rptr_sync)
  );

  dcfifo_ram #(.DW(DW), .AW(AW)) u_ram (
    .wr_clk(wr_clk), .we(mem_we), .waddr(mem_waddr), .wdata(mem_wdata),
    .raddr(mem_raddr), .rdata(mem_rdata)
  );

  dcfifo_rside #(.DW(DW), .AW(AW), .OW(OW)) u_rside (
    .rd_clk(rd_clk), .rst_n(rst_n), .rd_en1_n(rd_en1_n), .rd_en2_n(rd_en2_n),
    .wptr_sync(wptr_sync), .empty_thr(empty_thr), .mem_rdata(mem_rdata),
    .mem_raddr(mem_raddr), .rptr_gray(rptr_gray), .rd_fire(rd_fire),
    .dout_q(dout_q), .empty_n(empty_n), .aempty_n(aempty_n)
  );

  assign dout       = oe_n ? '0 : dout_q;
  assign dout_drive = !oe_n;
endmodule

// File: rtl/dcfifo_modes_chk.sv
`timescale 1ns/1ps
module dcfifo_modes_chk #(
  parameter int DW = 9
) (
  input logic          wr_clk,
  input logic          rd_clk,
  input logic          rst_n,
  input logic          wr_en1_n,
  input logic          wr_en2_ld,
  input logic          oe_n,
  input logic [DW-1:0] dout,
  input logic          dout_drive,
  input logic [DW-1:0] dout_q,
  input logic          full_n,
  input logic          afull_n,
  input logic          empty_n,
  input logic          aempty_n,
  input logic          wr_fire,
  input logic          rd_fire,
  input logic          ofs_load,
  input logic          mode_dual
);
  p_wr_reset_r1: assert property (@(posedge wr_clk)
    !rst_n |=> (full_n && afull_n));
  p_rd_reset_r1: assert property (@(posedge rd_clk)
    !rst_n |=> (!empty_n && !aempty_n && dout_q == '0));
  p_mode_hold_r2: assert property (@(posedge wr_clk) disable iff (!rst_n)
    rst_n |=> $stable(mode_dual));
  p_dual_gate_r3: assert property (@(posedge wr_clk) disable iff (!rst_n)
    (mode_dual && wr_fire) |-> (!wr_en1_n && wr_en2_ld));
  p_dual_noload_r3: assert property (@(posedge wr_clk) disable iff (!rst_n)
    mode_dual |-> !ofs_load);
  p_load_not_array_r4: assert property (@(posedge wr_clk) disable iff (!rst_n)
    ofs_load |-> !wr_fire);
  p_hold_r5: assert property (@(posedge rd_clk) disable iff (!rst_n)
    !rd_fire |=> $stable(dout_q));
  p_no_underflow_r6: assert property (@(posedge rd_clk) disable iff (!rst_n)
    !empty_n |-> !rd_fire);
  p_no_overflow_r7: assert property (@(posedge wr_clk) disable iff (!rst_n)
    !full_n |-> !wr_fire);
  p_empty_implies_low_r8: assert property (@(posedge rd_clk) disable iff (!rst_n)
    !empty_n |-> !aempty_n);
  p_full_implies_high_r9: assert property (@(posedge wr_clk) disable iff (!rst_n)
    !full_n |-> !afull_n);
  p_oe_r10: assert property (@(posedge rd_clk) disable iff (!rst_n)
    oe_n |-> (dout == '0 && !dout_drive));
endmodule

bind dcfifo_modes dcfifo_modes_chk #(.DW(DW)) u_chk (
  .wr_clk(wr_clk), .rd_clk(rd_clk), .rst_n(rst_n), .wr_en1_n(wr_en1_n),
  .wr_en2_ld(wr_en2_ld), .oe_n(oe_n), .dout(dout), .dout_drive(dout_drive),
  .dout_q(dout_q), .full_n(full_n), .afull_n(afull_n), .empty_n(empty_n),
  .aempty_n(aempty_n), .wr_fire(wr_fire), .rd_fire(rd_fire),
  .ofs_load(ofs_load), .mode_dual(mode_dual)
);

// File: tb/dcfifo_modes_tb.sv
`timescale 1ns/1ps
module dcfifo_modes_tb;
  logic wclk = 1'b0, rclk = 1'b0;
  logic rst_n = 1'b0;
  logic we1_n = 1'b1, we2_ld = 1'b1;
  logic [8:0] din = '0;
  logic re1_n = 1'b1, re2_n = 1'b1, oe_n = 1'b0;
  logic [8:0] dout;
  logic drive, full_n, afull_n, empty_n, aempty_n;

  int nvec = 0, nbad = 0;
  bit done = 1'b0;
  logic [8:0] model_q [$];
  logic [8:0] last_out = '0;

  always #10 wclk = ~wclk;                     // 50 MHz write clock
  initial begin #7; forever #10 rclk = ~rclk; end  // same rate, offset phase

  dcfifo_modes u_dut (
    .wr_clk(wclk), .rd_clk(rclk), .rst_n(rst_n), .wr_en1_n(we1_n),
    .wr_en2_ld(we2_ld), .din(din), .rd_en1_n(re1_n), .rd_en2_n(re2_n),
    .oe_n(oe_n), .dout(dout), .dout_drive(drive), .full_n(full_n),
    .afull_n(afull_n), .empty_n(empty_n), .aempty_n(aempty_n)
  );

  // op in [11:9]: 0 write, 1 read, 2 read with enable one high,
  // 3 read with enable two high, 4 output disabled, 5 settle
  localparam logic [11:0] VEC [18] = '{
    {3'd0, 9'h1A5}, {3'd0, 9'h05A}, {3'd0, 9'h0FF}, {3'd0, 9'h100},
    {3'd5, 9'h000}, {3'd1, 9'h000}, {3'd2, 9'h000}, {3'd3, 9'h000},
    {3'd1, 9'h000}, {3'd4, 9'h000}, {3'd1, 9'h000}, {3'd0, 9'h1FF},
    {3'd0, 9'h000}, {3'd5, 9'h000}, {3'd1, 9'h000}, {3'd1, 9'h000},
    {3'd1, 9'h000}, {3'd5, 9'h000}
  };

  task automatic check(input string tag, input logic [15:0] act, input logic [15:0] exp);
    nvec++;
    if (act !== exp) begin
      nbad++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic do_reset(input logic mode_pin);
    @(negedge wclk);
    rst_n = 1'b0; we2_ld = mode_pin; we1_n = 1'b1;
    repeat (5) @(negedge wclk);
    rst_n = 1'b1;
    @(negedge wclk);
    we2_ld = 1'b1;
    model_q.delete();
    last_out = '0;
  endtask

  task automatic wr(input logic e1, input logic e2, input logic [8:0] d);
    @(negedge wclk);
    we1_n = e1; we2_ld = e2; din = d;
    @(negedge wclk);
    we1_n = 1'b1; we2_ld = 1'b1;
  endtask

  task automatic rd(input logic e1, input logic e2);
    @(negedge rclk);
    re1_n = e1; re2_n = e2;
    @(negedge rclk);
    re1_n = 1'b1; re2_n = 1'b1;
  endtask

  task automatic settle();
    repeat (8) @(negedge wclk);
  endtask

  initial begin
    repeat (150000) @(posedge wclk);
    if (!done) begin
      nvec++; nbad++;
      $display("FAIL watchdog: run did not finish, actual=hung expected=done");
      $display("== %0d vectors applied, %0d miscompares ==", nvec, nbad);
      $finish;
    end
  end

  initial begin
    // ---- R1 reset state (dual-enable mode) ----
    do_reset(1'b1);
    @(negedge rclk);
    check("R1 full_n after reset", 16'(full_n), 16'd1);
    check("R1 afull_n after reset", 16'(afull_n), 16'd1);
    check("R1 empty_n after reset", 16'(empty_n), 16'd0);
    check("R1 aempty_n after reset", 16'(aempty_n), 16'd0);
    check("R1 dout after reset", 16'(dout), 16'd0);

    // ---- table walk: R5, R10, R11 ----
    for (int i = 0; i < 18; i++) begin
      logic [2:0] op;
      logic [8:0] val;
      op  = VEC[i][11:9];
      val = VEC[i][8:0];
      case (op)
        3'd0: begin wr(1'b0, 1'b1, val); model_q.push_back(val); end
        3'd1: begin
          rd(1'b0, 1'b0);
          last_out = model_q.pop_front();
          check("R11 read order and data", 16'(dout), 16'(last_out));
        end
        3'd2: begin rd(1'b1, 1'b0); check("R5 hold with enable one high", 16'(dout), 16'(last_out)); end
        3'd3: begin rd(1'b0, 1'b1); check("R5 hold with enable two high", 16'(dout), 16'(last_out)); end
        3'd4: begin
          @(negedge rclk); oe_n = 1'b1;
          @(negedge rclk);
          check("R10 dout zero when disabled", 16'(dout), 16'd0);
          check("R10 drive low when disabled", 16'(drive), 16'd0);
          oe_n = 1'b0;
          @(negedge rclk);
          check("R10 drive high when enabled", 16'(drive), 16'd1);
        end
        default: settle();
      endcase
    end

    // ---- R6: read while empty is ignored ----
    @(negedge rclk);
    check("R6 empty_n low after draining", 16'(empty_n), 16'd0);
    rd(1'b0, 1'b0);
    check("R6 read while empty ignored", 16'(dout), 16'(last_out));

    // ---- R3: gating in dual-enable mode ----
    wr(1'b0, 1'b0, 9'h155);
    wr(1'b1, 1'b1, 9'h0AA);
    settle();
    check("R3 no store unless en1 low and en2 high", 16'(empty_n), 16'd0);

    // ---- R7, R8, R9: fill in dual-enable mode with default thresholds ----
    do_reset(1'b1);
    for (int n = 1; n <= 256; n++) begin
      wr(1'b0, 1'b1, 9'(n - 1));
      if (n == 7 || n == 8) begin
        settle();
        @(negedge rclk);
        check($sformatf("R8 aempty_n at %0d words", n), 16'(aempty_n), (n == 7) ? 16'd0 : 16'd1);
      end
      if (n == 1) begin
        settle();
        check("R6 empty_n rises after write", 16'(empty_n), 16'd1);
      end
      if (n == 248) check("R9 afull_n with free 8", 16'(afull_n), 16'd1);
      if (n == 249) check("R9 afull_n with free 7", 16'(afull_n), 16'd0);
      if (n == 255) check("R7 full_n at 255 words", 16'(full_n), 16'd1);
      if (n == 256) check("R7 full_n at 256 words", 16'(full_n), 16'd0);
    end
    wr(1'b0, 1'b1, 9'h1EE);
    check("R7 full_n stays low on write attempt", 16'(full_n), 16'd0);
    rd(1'b0, 1'b0);
    check("R11 first word after fill", 16'(dout), 16'd0);
    settle();
    check("R7 full_n rises after read", 16'(full_n), 16'd1);
    begin
      int errs = 0;
      for (int k = 1; k < 256; k++) begin
        rd(1'b0, 1'b0);
        if (dout !== 9'(k)) errs++;
      end
      check("R11 remaining 255 words in order", 16'(errs), 16'd0);
    end
    settle();
    check("R7 extra write while full was dropped", 16'(empty_n), 16'd0);

    // ---- R2, R4: threshold mode, loaded offsets ----
    do_reset(1'b0);
    wr(1'b0, 1'b0, 9'h002);   // empty threshold low byte
    wr(1'b0, 1'b0, 9'h100);   // empty threshold high byte (bit 8 not used)
    wr(1'b0, 1'b0, 9'h003);   // full threshold low byte
    wr(1'b0, 1'b0, 9'h000);   // full threshold high byte
    settle();
    check("R4 offset loads do not enter array", 16'(empty_n), 16'd0);
    wr(1'b0, 1'b1, 9'h011);
    wr(1'b0, 1'b1, 9'h022);
    settle();
    check("R2 threshold mode stores with strobe high", 16'(empty_n), 16'd1);
    check("R4 aempty_n at 2 words, threshold 2", 16'(aempty_n), 16'd0);
    wr(1'b0, 1'b1, 9'h033);
    settle();
    check("R4 aempty_n at 3 words, threshold 2", 16'(aempty_n), 16'd1);
    wr(1'b0, 1'b0, 9'h005);   // fifth load wraps to empty low byte
    settle();
    check("R4 load order wraps to empty low byte", 16'(aempty_n), 16'd0);
    for (int n = 4; n <= 253; n++) begin
      wr(1'b0, 1'b1, 9'(n));
      if (n == 252) check("R9 afull_n with free 4, threshold 3", 16'(afull_n), 16'd1);
      if (n == 253) check("R9 afull_n with free 3, threshold 3", 16'(afull_n), 16'd0);
    end
    rd(1'b0, 1'b0);
    check("R11 first word in threshold mode", 16'(dout), 16'h011);

    // ---- R2: dual mode strobe-low does not load offsets ----
    do_reset(1'b1);
    wr(1'b0, 1'b0, 9'h0F0);
    for (int n = 1; n <= 7; n++) wr(1'b0, 1'b1, 9'(n));
    settle();
    check("R2 dual mode keeps default threshold", 16'(aempty_n), 16'd0);

    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", nvec, nbad);
    $finish;
  end
endmodule